// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the control and status logic for an analog-to-digital converter inside a microcontroller. Software sets or clears a start bit and picks single or continuous operation. The sequencer then issues one-cycle conversion request pulses to the converter. It counts the conversion-done pulses that come back and decides when a sequence is over. It watches the converter's extended-acquisition indication so that a stop can be immediate or deferred. It also forces a stop when the device enters a low-power mode.

Beside the sequencing, the block tracks reference readiness with a settle timer and holds a data-available flag. The event that sets the flag is chosen by a 2-bit field. The interrupt output is the flag gated by an enable and a global mask. The converter and the analog reference are outside the block and appear only as handshake inputs.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `ref_ok_o` is 0 after any clock edge that samples `ref_en_i` low. It becomes 1 after `REF_SETTLE_CYC` consecutive edges that sample `ref_en_i` high.
- R2: A write of 1 (`start_wr_i`=1, `start_wdata_i`=1) while idle and not blocked sets `start_o` and `busy_o` at that edge. `conv_req_o` is then high for exactly the following cycle.
- R3: With `cont_mode_i`=0, the sequence ends at the edge that accepts the `SEQ_LEN`-th `conv_done_i`. At that edge `start_o` and `busy_o` clear and no further request follows.
- R4: With `cont_mode_i`=1, requests continue past `SEQ_LEN` conversions and `start_o` stays 1 until software writes 0.
- R5: A write of 0 while a conversion is in progress and `acq_ext_i`=0 clears `start_o` at that edge. `busy_o` stays 1 until the edge that samples `conv_done_i`, and no request follows.
- R6: A write of 0 while waiting on the converter with `acq_ext_i`=1 clears `start_o` and `busy_o` at that same edge.
- R7: While `stop_mode_i`=1, `start_o` and `busy_o` are 0 from the next edge, and writes of 1 do not start a sequence.
- R8: A rising edge of `pmm_mode_i` clears `start_o` and `busy_o`. While `pmm_mode_i`=1, a write of 1 starts a sequence only if `swb_en_i`=1.
- R9: A write of 1 while `busy_o`=1 clears `flag_o` and does not change `start_o`, `busy_o` or the sequence position.
- R10: `flag_o` is set on an accepted `conv_done_i` according to `int_mode_i`. The code 00 or 11 sets it on every conversion. The code 01 sets it on the conversion that completes a sequence of `SEQ_LEN`. The code 10 sets it when the count of conversions since start, modulo `BUF_DEPTH`, equals `BUF_DEPTH/2`.
- R11: `flag_o` clears on any write of 1 to the start bit and on `flag_clr_i`. A set event in the same cycle wins over a clear.
- R12: `irq_o` is 1 exactly when `flag_o`=1, `int_en_i`=1 and `int_mask_i`=0.
- R13: After reset, `start_o`, `busy_o`, `conv_req_o`, `flag_o`, `irq_o` and `ref_ok_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_wr_i | input | 1 | Software write strobe for the start bit |
| start_wdata_i | input | 1 | Value written to the start bit |
| cont_mode_i | input | 1 | 1 = continuous, 0 = single sequence |
| int_mode_i | input | 2 | Flag event select (see R10) |
| flag_clr_i | input | 1 | Software clear of the data-available flag |
| int_en_i | input | 1 | Interrupt enable |
| int_mask_i | input | 1 | Global interrupt mask |
| stop_mode_i | input | 1 | Device is in stop mode |
| pmm_mode_i | input | 1 | Device is in power-management mode |
| swb_en_i | input | 1 | Switchback enable, allows start in power-management mode |
| ref_en_i | input | 1 | Internal reference enable |
| conv_done_i | input | 1 | Converter finished a conversion |
| acq_ext_i | input | 1 | Converter is in an extended acquisition period |
| conv_req_o | output | 1 | One-cycle conversion request |
| start_o | output | 1 | Start bit value |
| busy_o | output | 1 | A sequence is active |
| flag_o | output | 1 | Data-available flag |
| irq_o | output | 1 | Interrupt request |
| ref_ok_o | output | 1 | Reference ready |

## Verification
All four flag-event codes are swept against both single and continuous operation. Each conversion's flag value is compared with a count-based formula, so the codes that share timing are told apart: 01 and 10 coincide at the fourth conversion but split at the eighth. Stop writes are tried with the acquisition indication low and high, to separate the deferred stop from the immediate one. Starts are tried under stop mode, and under power-management mode with and without switchback, to show which gating applies. A mid-sequence rewrite of 1 is followed by counting the remaining conversions, which shows that the sequence position was not reset.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  localparam logic [1:0] IRQ_EACH = 2'b00;
  localparam logic [1:0] IRQ_SEQ  = 2'b01;
  localparam logic [1:0] IRQ_HALF = 2'b10;
endpackage

// File: rtl/adc_ref_monitor.sv
module adc_ref_monitor #(
  parameter int unsigned REF_SETTLE_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_en_i,
  output logic ref_ok_o
);
  generate
    if (REF_SETTLE_CYC == 0) begin : g_no_settle
      logic en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= ref_en_i;
      end
      assign ref_ok_o = en_q;
    end else begin : g_settle
      localparam int unsigned CW = $clog2(REF_SETTLE_CYC + 1);
      localparam logic [CW-1:0] LIMIT = CW'(REF_SETTLE_CYC);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (!ref_en_i)       cnt_q <= '0;
        else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
      end
      assign ref_ok_o = (cnt_q == LIMIT);
    end
  endgenerate

  AST_REF_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_en_i |=> !ref_ok_o); // R1
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned SEQ_LEN   = 4,
  parameter int unsigned BUF_DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic start_wdata_i,
  input  logic cont_mode_i,
  input  logic stop_mode_i,
  input  logic pmm_mode_i,
  input  logic swb_en_i,
  input  logic conv_done_i,
  input  logic acq_ext_i,
  output logic conv_req_o,
  output logic start_o,
  output logic busy_o,
  output logic conv_evt_o,
  output logic seq_end_evt_o,
  output logic half_evt_o
);
  localparam int unsigned SEQ_CW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam int unsigned BUF_AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam logic [SEQ_CW-1:0] SEQ_LAST = SEQ_CW'(SEQ_LEN - 1);
  localparam logic [BUF_AW-1:0] BUF_LAST = BUF_AW'(BUF_DEPTH - 1);
  localparam logic [BUF_AW-1:0] HALF_PRE = BUF_AW'(BUF_DEPTH / 2 - 1);

  seq_state_e        state_q, state_d;
  logic              start_q, start_d;
  logic              pmm_q;
  logic [SEQ_CW-1:0] seq_q, seq_d;
  logic [BUF_AW-1:0] ptr_q, ptr_d;

  logic pmm_enter, force_stop, start_acc, stop_wr, stopping;
  logic conv_evt, seq_last;

  assign pmm_enter  = pmm_mode_i && !pmm_q;
  assign force_stop = stop_mode_i || pmm_enter;
  assign busy_o     = (state_q != ST_IDLE);
  assign start_acc  = start_wr_i && start_wdata_i && !busy_o && !force_stop &&
                      (!pmm_mode_i || swb_en_i);
  assign stop_wr    = start_wr_i && !start_wdata_i;
  assign stopping   = stop_wr || !start_q;
  assign conv_evt   = (state_q == ST_WAIT) && conv_done_i && !force_stop;
  assign seq_last   = conv_evt && (seq_q == SEQ_LAST);

  always_comb begin
    state_d = state_q;
    start_d = start_q;
    seq_d   = seq_q;
    ptr_d   = ptr_q;
    if (force_stop) begin
      state_d = ST_IDLE;
      start_d = 1'b0;
    end else if (start_acc) begin
      state_d = ST_REQ;
      start_d = 1'b1;
      seq_d   = '0;
      ptr_d   = '0;
    end else begin
      if (stop_wr) start_d = 1'b0;
      unique case (state_q)
        ST_REQ: state_d = ST_WAIT;
        ST_WAIT: begin
          if (conv_evt) begin
            seq_d = seq_last ? '0 : seq_q + 1'b1;
            ptr_d = (ptr_q == BUF_LAST) ? '0 : ptr_q + 1'b1;
            if (stopping) begin
              state_d = ST_IDLE;
            end else if (seq_last && !cont_mode_i) begin
              state_d = ST_IDLE;
              start_d = 1'b0;
            end else begin
              state_d = ST_REQ;
            end
          end else if (stopping && acq_ext_i) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      pmm_q   <= 1'b0;
      seq_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      pmm_q   <= pmm_mode_i;
      seq_q   <= seq_d;
      ptr_q   <= ptr_d;
    end
  end

  assign conv_req_o    = (state_q == ST_REQ);
  assign start_o       = start_q;
  assign conv_evt_o    = conv_evt;
  assign seq_end_evt_o = seq_last;
  assign half_evt_o    = conv_evt && (ptr_q == HALF_PRE);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o); // R2
  AST_SINGLE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_last && !cont_mode_i) |=> (!start_o && !busy_o)); // R3
  AST_CONT_GOES_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_last && cont_mode_i && start_q && !stop_wr) |=> (start_o && conv_req_o)); // R4
  AST_STOP_DEFERRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && !start_q && !conv_done_i && !acq_ext_i && !force_stop)
      |=> busy_o); // R5
  AST_STOP_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && stopping && acq_ext_i && !force_stop) |=> !busy_o); // R6
  AST_STOP_MODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_mode_i |=> (!start_o && !busy_o)); // R7
  AST_PMM_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmm_mode_i && !swb_en_i && !start_q) |=> !start_o); // R8
  AST_START_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o); // R9
endmodule

// File: rtl/adc_flag_irq.sv
module adc_flag_irq
  import adc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] int_mode_i,
  input  logic       conv_evt_i,
  input  logic       seq_end_evt_i,
  input  logic       half_evt_i,
  input  logic       start_one_wr_i,
  input  logic       flag_clr_i,
  input  logic       int_en_i,
  input  logic       int_mask_i,
  output logic       flag_o,
  output logic       irq_o
);
  logic flag_q, set_evt, clr_evt;

  always_comb begin
    unique case (int_mode_i)
      IRQ_SEQ:  set_evt = seq_end_evt_i;
      IRQ_HALF: set_evt = half_evt_i;
      default:  set_evt = conv_evt_i;
    endcase
  end

  assign clr_evt = start_one_wr_i || flag_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && int_en_i && !int_mask_i;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> flag_o); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_evt && !set_evt) |=> !flag_o); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_evt && !set_evt) |=> $stable(flag_o)); // R11
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned SEQ_LEN        = 4,
  parameter int unsigned BUF_DEPTH      = 8,
  parameter int unsigned REF_SETTLE_CYC = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_wr_i,
  input  logic       start_wdata_i,
  input  logic       cont_mode_i,
  input  logic [1:0] int_mode_i,
  input  logic       flag_clr_i,
  input  logic       int_en_i,
  input  logic       int_mask_i,
  input  logic       stop_mode_i,
  input  logic       pmm_mode_i,
  input  logic       swb_en_i,
  input  logic       ref_en_i,
  input  logic       conv_done_i,
  input  logic       acq_ext_i,
  output logic       conv_req_o,
  output logic       start_o,
  output logic       busy_o,
  output logic       flag_o,
  output logic       irq_o,
  output logic       ref_ok_o
);
  logic conv_evt, seq_end_evt, half_evt;

  adc_ref_monitor #(.REF_SETTLE_CYC(REF_SETTLE_CYC)) i_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_en_i (ref_en_i),
    .ref_ok_o (ref_ok_o)
  );

  adc_seq_fsm #(.SEQ_LEN(SEQ_LEN), .BUF_DEPTH(BUF_DEPTH)) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_wr_i    (start_wr_i),
    .start_wdata_i (start_wdata_i),
    .cont_mode_i   (cont_mode_i),
    .stop_mode_i   (stop_mode_i),
    .pmm_mode_i    (pmm_mode_i),
    .swb_en_i      (swb_en_i),
    .conv_done_i   (conv_done_i),
    .acq_ext_i     (acq_ext_i),
    .conv_req_o    (conv_req_o),
    .start_o       (start_o),
    .busy_o        (busy_o),
    .conv_evt_o    (conv_evt),
    .seq_end_evt_o (seq_end_evt),
    .half_evt_o    (half_evt)
  );

  adc_flag_irq i_flag (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .int_mode_i     (int_mode_i),
    .conv_evt_i     (conv_evt),
    .seq_end_evt_i  (seq_end_evt),
    .half_evt_i     (half_evt),
    .start_one_wr_i (start_wr_i && start_wdata_i),
    .flag_clr_i     (flag_clr_i),
    .int_en_i       (int_en_i),
    .int_mask_i     (int_mask_i),
    .flag_o         (flag_o),
    .irq_o          (irq_o)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && !int_mask_i)); // R12
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int SEQ_LEN = 4;
  localparam int BUF_DEPTH = 8;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_wr = 0, start_wdata = 0, cont_mode = 0, flag_clr = 0;
  logic [1:0] int_mode = 2'b00;
  logic int_en = 1, int_mask = 0, stop_mode = 0, pmm_mode = 0, swb_en = 0;
  logic ref_en = 0, conv_done = 0, acq_ext = 0;
  logic conv_req, start_s, busy, flag, irq, ref_ok;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl #(.SEQ_LEN(SEQ_LEN), .BUF_DEPTH(BUF_DEPTH), .REF_SETTLE_CYC(SETTLE)) i_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_wr_i(start_wr), .start_wdata_i(start_wdata),
    .cont_mode_i(cont_mode), .int_mode_i(int_mode), .flag_clr_i(flag_clr),
    .int_en_i(int_en), .int_mask_i(int_mask), .stop_mode_i(stop_mode),
    .pmm_mode_i(pmm_mode), .swb_en_i(swb_en), .ref_en_i(ref_en),
    .conv_done_i(conv_done), .acq_ext_i(acq_ext), .conv_req_o(conv_req),
    .start_o(start_s), .busy_o(busy), .flag_o(flag), .irq_o(irq), .ref_ok_o(ref_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_start(input logic v);
    start_wr = 1'b1;
    start_wdata = v;
    tick();
    start_wr = 1'b0;
  endtask

  // expects state with request high; ends right after the done edge
  task automatic conv_cycle(input string req);
    chk({req, " req high"}, conv_req, 1);
    tick();
    chk({req, " req one cycle"}, conv_req, 0);
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk("R11 flag_clr", flag, 0);
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
  endtask

  function automatic logic exp_flag(input int mode, input int k);
    case (mode)
      1: return (k % SEQ_LEN) == 0;
      2: return (k % BUF_DEPTH) == BUF_DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R13 reset state
    chk("R13 start", start_s, 0);
    chk("R13 busy", busy, 0);
    chk("R13 req", conv_req, 0);
    chk("R13 flag", flag, 0);
    chk("R13 irq", irq, 0);
    chk("R13 ref_ok", ref_ok, 0);
    rst_n = 1'b1;
    tick();

    // R1 reference settle
    ref_en = 1'b1;
    repeat (SETTLE - 1) tick();
    chk("R1 settling", ref_ok, 0);
    tick();
    chk("R1 settled", ref_ok, 1);
    ref_en = 1'b0;
    tick();
    chk("R1 disabled", ref_ok, 0);

    // R10 sweep over modes and single/continuous
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 4; m++) begin
        int n;
        cont_mode = c[0];
        int_mode = m[1:0];
        n = c ? 10 : SEQ_LEN;
        wr_start(1'b1);
        chk("R2 start", start_s, 1);
        chk("R2 busy", busy, 1);
        chk("R11 start clears flag", flag, 0);
        for (int k = 1; k <= n; k++) begin
          if (c && k == n) begin
            chk("R2 req high", conv_req, 1);
            tick();
            wr_start(1'b0);
            chk("R5 start cleared", start_s, 0);
            chk("R5 still busy", busy, 1);
            tick();
            chk("R5 waits", busy, 1);
            conv_done = 1'b1;
            tick();
            conv_done = 1'b0;
          end else begin
            conv_cycle("R2");
          end
          chk($sformatf("R10 mode%0d cont%0d k%0d", m, c, k), flag, exp_flag(m, k));
          chk("R12 irq follows flag", irq, exp_flag(m, k));
          if (k < n) begin
            chk("R4/R3 next req", conv_req, 1);
            chk("R4 start held", start_s, 1);
          end else begin
            chk(c ? "R5 idle after done" : "R3 idle at end", busy, 0);
            chk("R3 start clear", start_s, 0);
            chk("R3 no req", conv_req, 0);
          end
        end
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
      end
    end

    // R12 gating combos with flag set
    int_mode = 2'b00;
    cont_mode = 1'b0;
    wr_start(1'b1);
    conv_cycle("R12");
    for (int e = 0; e < 2; e++) begin
      for (int k = 0; k < 2; k++) begin
        int_en = e[0];
        int_mask = k[0];
        #1;
        chk("R12 irq gate", irq, (e == 1 && k == 0));
      end
    end
    int_en = 1'b1;
    int_mask = 1'b0;

    // R9 write 1 while busy: flag cleared, sequence position kept
    tick();
    chk("R9 waiting", conv_req, 0);
    wr_start(1'b1);
    chk("R9 flag cleared", flag, 0);
    chk("R9 start kept", start_s, 1);
    chk("R9 busy kept", busy, 1);
    chk("R9 no extra req", conv_req, 0);
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
    conv_cycle("R9");
    conv_cycle("R9");
    chk("R9 ends after four total", busy, 0);

    // R11 set wins over clear
    wr_start(1'b1);
    tick();
    flag_clr = 1'b1;
    conv_done = 1'b1;
    tick();
    flag_clr = 1'b0;
    conv_done = 1'b0;
    chk("R11 set wins", flag, 1);

    // R6 immediate stop during extended acquisition
    tick();
    acq_ext = 1'b1;
    wr_start(1'b0);
    acq_ext = 1'b0;
    chk("R6 start", start_s, 0);
    chk("R6 busy", busy, 0);
    chk("R6 req", conv_req, 0);

    // R7 stop mode
    cont_mode = 1'b1;
    wr_start(1'b1);
    chk("R7 running", busy, 1);
    stop_mode = 1'b1;
    tick();
    chk("R7 start forced", start_s, 0);
    chk("R7 busy forced", busy, 0);
    wr_start(1'b1);
    chk("R7 start blocked", start_s, 0);
    chk("R7 busy blocked", busy, 0);
    stop_mode = 1'b0;
    tick();

    // R8 power-management mode
    wr_start(1'b1);
    pmm_mode = 1'b1;
    tick();
    chk("R8 entry stops", busy, 0);
    chk("R8 entry clears start", start_s, 0);
    swb_en = 1'b0;
    wr_start(1'b1);
    chk("R8 blocked", start_s, 0);
    chk("R8 blocked busy", busy, 0);
    swb_en = 1'b1;
    wr_start(1'b1);
    chk("R8 switchback start", start_s, 1);
    chk("R8 switchback req", conv_req, 1);
    pmm_mode = 1'b0;
    swb_en = 1'b0;
    wr_start(1'b0);
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
    chk("R8 cleanup idle", busy, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule